// File: doc/BRIEF.md
# Rotating-Priority Interrupt Request Resolver

This block takes eight interrupt request lines and decides, every cycle, whether one of them should be signalled to the processor, and which one. Each line is captured either on a rising edge or as a level, as chosen by a per-line trigger-mode bit. The block holds four registers: the pending-request vector, the mask vector, the in-service vector and a 3-bit rotation offset that decides which line currently has top priority.

The winner is the highest-priority pending line that is not masked. It is reported only if it strictly outranks every line that is still in service. Two optional exceptions relax that comparison. Under special-mask operation, in-service lines that are masked do not count. On the master instance, under special nested operation, the cascade line's in-service bit does not count. Register writes, command decoding and cascading live outside the block. They reach it as write strobes with data, mode-enable bits, and per-bit set and clear pulses.

The block has no sequencing state: every register updates on a single clock edge, and the result is a pure function of the registers.

Top module: `rpr_resolver`

## Requirements
- R1: Synchronous active-high `rst` clears every register, including the trigger modes. A `reinit` pulse clears the pending, in-service, mask, previous-level and offset registers but keeps the trigger modes. In either case `irq_valid` is 0 in the following cycle.
- R2: A line whose trigger bit is 1 (level) has its pending bit and previous level both equal to the `irq_in` value sampled at the last clock edge.
- R3: A line whose trigger bit is 0 (edge) becomes pending only when its input is 1 and its previous level is 0. A falling input or a held-high input leaves the pending bit unchanged.
- R4: Only lines that are pending and whose mask bit is 0 can win. A mask bit of 1 blocks its line.
- R5: Line `offset` has the top priority and priority falls walking upward modulo 8. The priority value of line i is (i - offset) mod 8. `irq_index` reports the winning line number.
- R6: `irq_valid` is 1 only when the candidate's priority value is strictly smaller than the best priority value among the counted in-service bits. An empty set counts as value 8.
- R7: With `special_mask_en` = 1, in-service bits whose mask bit is 1 are left out of the in-service comparison.
- R8: With `special_nested_en` = 1, an instance built with IS_MASTER=1 leaves in-service bit 2 (the cascade line) out of the comparison. An instance built with IS_MASTER=0 ignores the enable.
- R9: A trigger write stores `trig_data` AND TRIG_ALLOW. The master default TRIG_ALLOW is 8'hF8, so lines 0-2 stay edge-triggered. The slave uses 8'hDE.
- R10: `isr_set`, `isr_clr` and `irr_clr` act per bit at the next edge, and a set wins over a clear on the same bit. A mask write loads `mask_data`, an offset write loads `rot_data`, and the outputs reflect the new registers in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reinit | input | 1 | Controller reinitialisation pulse |
| irq_in | input | 8 | Raw interrupt request lines |
| trig_wr | input | 1 | Trigger-mode write strobe |
| trig_data | input | 8 | Trigger modes, 1 = level, 0 = edge |
| mask_wr | input | 1 | Mask write strobe |
| mask_data | input | 8 | New mask vector, 1 = blocked |
| rot_wr | input | 1 | Rotation offset write strobe |
| rot_data | input | 3 | New rotation offset |
| isr_set | input | 8 | Per-bit in-service set pulses |
| isr_clr | input | 8 | Per-bit in-service clear pulses |
| irr_clr | input | 8 | Per-bit pending clear pulses |
| special_mask_en | input | 1 | Ignore masked in-service bits |
| special_nested_en | input | 1 | Master only: ignore in-service cascade bit |
| irq_valid | output | 1 | A line should be signalled |
| irq_index | output | 3 | Winning line number |

## Verification
The bench targets the following corner cases:
- An edge line whose input falls, or stays high after it is cleared. A design that treats edges as levels would drop or re-raise the request.
- A candidate whose priority equals the best in-service priority. A non-strict compare would wrongly signal it.
- Offsets that wrap the search past line 7. An unrotated or off-by-one search would name the wrong line.
- Each exception to the in-service comparison, applied on both the master and the slave.
- The allow mask, the differing trigger modes of the two instances, and a `reinit` that keeps the trigger modes while clearing everything else.

A long stretch of random stimulus is checked every cycle against a behavioural model.

// File: rtl/rpr_pkg.sv
package rpr_pkg;
    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_mode_e;
endpackage

// File: rtl/rpr_line_capture.sv
module rpr_line_capture
    import rpr_pkg::*;
#(
    parameter int NUM_LINES = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reinit,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic [NUM_LINES-1:0] trig,
    input  logic [NUM_LINES-1:0] irr_clr,
    output logic [NUM_LINES-1:0] irr
);
    logic [NUM_LINES-1:0] irr_q;
    logic [NUM_LINES-1:0] last_q;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        logic irr_n;
        logic last_n;
        trig_mode_e mode;

        assign mode = trig_mode_e'(trig[g]);

        always_comb begin
            irr_n  = irr_q[g];
            last_n = irq_in[g];
            unique case (mode)
                TRIG_LEVEL: irr_n = irq_in[g];
                TRIG_EDGE:  irr_n = (irr_q[g] & ~irr_clr[g])
                                  | (irq_in[g] & ~last_q[g]);
            endcase
        end

        always_ff @(posedge clk) begin
            if (rst || reinit) begin
                irr_q[g]  <= 1'b0;
                last_q[g] <= 1'b0;
            end else begin
                irr_q[g]  <= irr_n;
                last_q[g] <= last_n;
            end
        end
    end

    assign irr = irr_q;
endmodule

// File: rtl/rpr_prio_search.sv
module rpr_prio_search #(
    parameter int NUM_LINES = 8,
    localparam int IDX_W = $clog2(NUM_LINES),
    localparam int PRI_W = IDX_W + 1
) (
    input  logic [NUM_LINES-1:0] vec,
    input  logic [IDX_W-1:0]     off,
    output logic [PRI_W-1:0]     pri
);
    always_comb begin
        pri = PRI_W'(NUM_LINES);
        for (int k = NUM_LINES - 1; k >= 0; k--) begin
            logic [IDX_W-1:0] line;
            line = off + IDX_W'(k);
            if (vec[line]) begin
                pri = PRI_W'(k);
            end
        end
    end
endmodule

// File: rtl/rpr_resolver.sv
module rpr_resolver #(
    parameter int                   NUM_LINES    = 8,
    parameter bit                   IS_MASTER    = 1'b1,
    parameter logic [NUM_LINES-1:0] TRIG_ALLOW   = 8'hF8,
    parameter int                   CASCADE_LINE = 2,
    localparam int IDX_W = $clog2(NUM_LINES),
    localparam int PRI_W = IDX_W + 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reinit,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 trig_wr,
    input  logic [NUM_LINES-1:0] trig_data,
    input  logic                 mask_wr,
    input  logic [NUM_LINES-1:0] mask_data,
    input  logic                 rot_wr,
    input  logic [IDX_W-1:0]     rot_data,
    input  logic [NUM_LINES-1:0] isr_set,
    input  logic [NUM_LINES-1:0] isr_clr,
    input  logic [NUM_LINES-1:0] irr_clr,
    input  logic                 special_mask_en,
    input  logic                 special_nested_en,
    output logic                 irq_valid,
    output logic [IDX_W-1:0]     irq_index
);
    localparam logic [NUM_LINES-1:0] CASC_BIT = NUM_LINES'(1) << CASCADE_LINE;

    logic [NUM_LINES-1:0] trig_q;
    logic [NUM_LINES-1:0] imr_q;
    logic [NUM_LINES-1:0] isr_q;
    logic [IDX_W-1:0]     off_q;
    logic [NUM_LINES-1:0] irr;
    logic [NUM_LINES-1:0] cand_vec;
    logic [NUM_LINES-1:0] isr_eff;
    logic [PRI_W-1:0]     cand_pri;
    logic [PRI_W-1:0]     isr_pri;

    rpr_line_capture #(.NUM_LINES(NUM_LINES)) u_capture (
        .clk     (clk),
        .rst     (rst),
        .reinit  (reinit),
        .irq_in  (irq_in),
        .trig    (trig_q),
        .irr_clr (irr_clr),
        .irr     (irr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_q <= '0;
        end else if (trig_wr) begin
            trig_q <= trig_data & TRIG_ALLOW;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || reinit) begin
            imr_q <= '0;
            isr_q <= '0;
            off_q <= '0;
        end else begin
            if (mask_wr) begin
                imr_q <= mask_data;
            end
            if (rot_wr) begin
                off_q <= rot_data;
            end
            isr_q <= (isr_q & ~isr_clr) | isr_set;
        end
    end

    assign cand_vec = irr & ~imr_q;

    always_comb begin
        isr_eff = isr_q;
        if (special_mask_en) begin
            isr_eff = isr_eff & ~imr_q;
        end
        if (IS_MASTER && special_nested_en) begin
            isr_eff = isr_eff & ~CASC_BIT;
        end
    end

    rpr_prio_search #(.NUM_LINES(NUM_LINES)) u_cand_search (
        .vec (cand_vec),
        .off (off_q),
        .pri (cand_pri)
    );

    rpr_prio_search #(.NUM_LINES(NUM_LINES)) u_isr_search (
        .vec (isr_eff),
        .off (off_q),
        .pri (isr_pri)
    );

    assign irq_valid = cand_pri < isr_pri;
    assign irq_index = cand_pri[IDX_W-1:0] + off_q;
endmodule

// File: rtl/rpr_checker.sv
module rpr_checker #(
    parameter int                   NUM_LINES    = 8,
    parameter bit                   IS_MASTER    = 1'b1,
    parameter logic [NUM_LINES-1:0] TRIG_ALLOW   = 8'hF8,
    parameter int                   CASCADE_LINE = 2,
    localparam int IDX_W = $clog2(NUM_LINES)
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 reinit,
    input logic                 trig_wr,
    input logic [NUM_LINES-1:0] irq_in,
    input logic [NUM_LINES-1:0] irr_clr,
    input logic                 special_nested_en,
    input logic [NUM_LINES-1:0] irr,
    input logic [NUM_LINES-1:0] imr,
    input logic [NUM_LINES-1:0] isr,
    input logic [NUM_LINES-1:0] trig,
    input logic                 irq_valid,
    input logic [IDX_W-1:0]     irq_index
);
    AST_REINIT_QUIET: assert property (@(posedge clk) disable iff (rst)
        reinit |=> !irq_valid); // R1

    AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (!reinit && !trig_wr) |=> ((irr & trig) == ($past(irq_in) & trig))); // R2

    AST_EDGE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!reinit && !trig_wr && irr_clr == '0)
        |=> (((irr & ~trig) & $past(irr & ~trig)) == $past(irr & ~trig))); // R3

    AST_WINNER_UNMASKED: assert property (@(posedge clk) disable iff (rst)
        irq_valid |-> (irr[irq_index] && !imr[irq_index])); // R4

    AST_WINNER_NOT_SERVED: assert property (@(posedge clk) disable iff (rst)
        (irq_valid && !(IS_MASTER && special_nested_en && int'(irq_index) == CASCADE_LINE))
        |-> !isr[irq_index]); // R6

    AST_TRIG_ALLOWED: assert property (@(posedge clk) disable iff (rst)
        (trig & ~TRIG_ALLOW) == '0); // R9
endmodule

bind rpr_resolver rpr_checker #(
    .NUM_LINES    (NUM_LINES),
    .IS_MASTER    (IS_MASTER),
    .TRIG_ALLOW   (TRIG_ALLOW),
    .CASCADE_LINE (CASCADE_LINE)
) u_rpr_checker (
    .clk               (clk),
    .rst               (rst),
    .reinit            (reinit),
    .trig_wr           (trig_wr),
    .irq_in            (irq_in),
    .irr_clr           (irr_clr),
    .special_nested_en (special_nested_en),
    .irr               (irr),
    .imr               (imr_q),
    .isr               (isr_q),
    .trig              (trig_q),
    .irq_valid         (irq_valid),
    .irq_index         (irq_index)
);

// File: tb/rpr_resolver_bench.sv
module rpr_resolver_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reinit = 1'b0;
    logic [7:0] irq_in = '0;
    logic       trig_wr = 1'b0;
    logic [7:0] trig_data = '0;
    logic       mask_wr = 1'b0;
    logic [7:0] mask_data = '0;
    logic       rot_wr = 1'b0;
    logic [2:0] rot_data = '0;
    logic [7:0] isr_set = '0;
    logic [7:0] isr_clr = '0;
    logic [7:0] irr_clr = '0;
    logic       special_mask_en = 1'b0;
    logic       special_nested_en = 1'b0;
    logic       m_valid, s_valid;
    logic [2:0] m_index, s_index;

    int errors = 0;
    int checks = 0;
    string cur_req = "R1";

    int md_irr[2], md_last[2], md_imr[2], md_isr[2], md_trig[2], md_off[2];
    int allow[2] = '{32'hF8, 32'hDE};

    always #5 clk = ~clk;

    rpr_resolver u_rpr_resolver (
        .clk(clk), .rst(rst), .reinit(reinit), .irq_in(irq_in),
        .trig_wr(trig_wr), .trig_data(trig_data), .mask_wr(mask_wr), .mask_data(mask_data),
        .rot_wr(rot_wr), .rot_data(rot_data), .isr_set(isr_set), .isr_clr(isr_clr),
        .irr_clr(irr_clr), .special_mask_en(special_mask_en),
        .special_nested_en(special_nested_en), .irq_valid(m_valid), .irq_index(m_index)
    );

    rpr_resolver #(.IS_MASTER(1'b0), .TRIG_ALLOW(8'hDE)) u_rpr_resolver_slv (
        .clk(clk), .rst(rst), .reinit(reinit), .irq_in(irq_in),
        .trig_wr(trig_wr), .trig_data(trig_data), .mask_wr(mask_wr), .mask_data(mask_data),
        .rot_wr(rot_wr), .rot_data(rot_data), .isr_set(isr_set), .isr_clr(isr_clr),
        .irr_clr(irr_clr), .special_mask_en(special_mask_en),
        .special_nested_en(special_nested_en), .irq_valid(s_valid), .irq_index(s_index)
    );

    function automatic int bitof(int v, int b);
        return (v >> b) & 1;
    endfunction

    task automatic model_update();
        for (int n = 0; n < 2; n++) begin
            if (rst) begin
                md_irr[n] = 0; md_last[n] = 0; md_imr[n] = 0;
                md_isr[n] = 0; md_trig[n] = 0; md_off[n] = 0;
                continue;
            end
            if (reinit) begin
                md_irr[n] = 0; md_last[n] = 0; md_imr[n] = 0;
                md_isr[n] = 0; md_off[n] = 0;
            end else begin
                int nirr = 0;
                for (int b = 0; b < 8; b++) begin
                    int p = bitof(md_irr[n], b);
                    if (bitof(md_trig[n], b) == 1) begin
                        p = bitof(irq_in, b);
                    end else begin
                        if (irr_clr[b]) p = 0;
                        if (irq_in[b] && bitof(md_last[n], b) == 0) p = 1;
                    end
                    nirr = nirr | (p << b);
                end
                md_irr[n]  = nirr;
                md_last[n] = irq_in;
                if (mask_wr) md_imr[n] = mask_data;
                if (rot_wr)  md_off[n] = rot_data;
                md_isr[n] = (md_isr[n] & ~int'(isr_clr) & 255) | isr_set;
            end
            if (trig_wr) md_trig[n] = trig_data & allow[n];
        end
    endtask

    function automatic int best(int v, int off);
        for (int k = 0; k < 8; k++) begin
            if (bitof(v, (off + k) % 8) == 1) return k;
        end
        return 8;
    endfunction

    task automatic compare(int n, logic v, logic [2:0] idx);
        int cp, ip, svc, ev, ei;
        cp  = best(md_irr[n] & ~md_imr[n] & 255, md_off[n]);
        svc = md_isr[n];
        if (special_mask_en) svc = svc & ~md_imr[n];
        if (n == 0 && special_nested_en) svc = svc & ~4;
        ip = best(svc & 255, md_off[n]);
        ev = (cp < ip) ? 1 : 0;
        ei = (cp + md_off[n]) % 8;
        checks++;
        if (int'(v) != ev || (ev == 1 && int'(idx) != ei)) begin
            errors++;
            $display("FAIL %s model inst%0d: got valid=%0d idx=%0d, expected valid=%0d idx=%0d",
                     cur_req, n, v, idx, ev, ei);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare(0, m_valid, m_index);
        compare(1, s_valid, s_index);
    endtask

    task automatic chk(int n, int ev, int ei, string req);
        logic v;
        logic [2:0] idx;
        v   = (n == 0) ? m_valid : s_valid;
        idx = (n == 0) ? m_index : s_index;
        checks++;
        if (int'(v) != ev || (ev == 1 && int'(idx) != ei)) begin
            errors++;
            $display("FAIL %s inst%0d: got valid=%0d idx=%0d, expected valid=%0d idx=%0d",
                     req, n, v, idx, ev, ei);
        end
    endtask

    task automatic clear_pulses();
        reinit = 0; trig_wr = 0; mask_wr = 0; rot_wr = 0;
        isr_set = '0; isr_clr = '0; irr_clr = '0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        cyc(); cyc();
        rst = 0;
        cyc();
        chk(0, 0, 0, "R1"); chk(1, 0, 0, "R1");

        cur_req = "R3";
        irq_in = 8'h20; cyc();
        chk(0, 1, 5, "R3"); chk(1, 1, 5, "R3");
        irq_in = 8'h00; cyc();
        chk(0, 1, 5, "R3 fall keeps pending"); chk(1, 1, 5, "R3 fall keeps pending");
        irq_in = 8'h20; cyc();
        irr_clr = 8'h20; cyc(); clear_pulses();
        chk(0, 0, 0, "R3 held high no retrigger"); chk(1, 0, 0, "R3 held high no retrigger");
        irq_in = 8'h00; cyc();

        cur_req = "R9";
        trig_wr = 1; trig_data = 8'hFF; cyc(); clear_pulses();
        irq_in = 8'h20; cyc();
        irq_in = 8'h00; cyc();
        chk(0, 0, 0, "R9 master line5 level"); chk(1, 1, 5, "R9 slave line5 edge");
        irr_clr = 8'h20; cyc(); clear_pulses();
        irq_in = 8'h02; cyc();
        irq_in = 8'h00; cyc();
        chk(0, 1, 1, "R9 master line1 edge"); chk(1, 0, 0, "R9 slave line1 level");
        irr_clr = 8'h02; cyc(); clear_pulses();

        cur_req = "R2";
        irq_in = 8'h08; cyc();
        chk(0, 1, 3, "R2"); chk(1, 1, 3, "R2");
        irq_in = 8'h00; cyc();
        chk(0, 0, 0, "R2 level drop"); chk(1, 0, 0, "R2 level drop");

        cur_req = "R4";
        mask_wr = 1; mask_data = 8'h08; irq_in = 8'h08; cyc(); clear_pulses();
        chk(0, 0, 0, "R4 masked"); chk(1, 0, 0, "R4 masked");
        mask_wr = 1; mask_data = 8'h00; cyc(); clear_pulses();
        chk(0, 1, 3, "R10 mask write"); chk(1, 1, 3, "R10 mask write");
        irq_in = 8'h00; cyc();

        cur_req = "R5";
        irq_in = 8'h42; cyc();
        chk(0, 1, 1, "R5 off0"); chk(1, 1, 1, "R5 off0");
        rot_wr = 1; rot_data = 3'd5; cyc(); clear_pulses();
        chk(0, 1, 6, "R5 off5"); chk(1, 1, 6, "R5 off5");
        rot_wr = 1; rot_data = 3'd2; cyc(); clear_pulses();
        chk(0, 1, 6, "R5 off2 wrap"); chk(1, 1, 6, "R5 off2 wrap");
        rot_wr = 1; rot_data = 3'd7; cyc(); clear_pulses();
        chk(0, 1, 1, "R5 off7 wrap"); chk(1, 1, 1, "R5 off7 wrap");
        irq_in = 8'h00; rot_wr = 1; rot_data = 3'd0; irr_clr = 8'h42; cyc(); clear_pulses();

        cur_req = "R6";
        isr_set = 8'h10; irq_in = 8'h40; cyc(); clear_pulses();
        chk(0, 0, 0, "R6 lower than service"); chk(1, 0, 0, "R6 lower than service");
        irq_in = 8'h04; cyc();
        chk(0, 1, 2, "R6 outranks"); chk(1, 1, 2, "R6 outranks");
        isr_set = 8'h04; cyc(); clear_pulses();
        chk(0, 0, 0, "R6 equal not strict"); chk(1, 0, 0, "R6 equal not strict");

        cur_req = "R8";
        special_nested_en = 1; cyc();
        chk(0, 1, 2, "R8 master ignores cascade"); chk(1, 0, 0, "R8 slave unaffected");
        special_nested_en = 0;

        cur_req = "R7";
        mask_wr = 1; mask_data = 8'h04; irq_in = 8'h0C; cyc(); clear_pulses();
        chk(0, 0, 0, "R7 off"); chk(1, 0, 0, "R7 off");
        special_mask_en = 1; cyc();
        chk(0, 1, 3, "R7 on"); chk(1, 1, 3, "R7 on");
        special_mask_en = 0;

        cur_req = "R10";
        isr_clr = 8'h14; isr_set = 8'h00; cyc(); clear_pulses();
        chk(0, 1, 3, "R10 isr clear"); chk(1, 1, 3, "R10 isr clear");
        isr_set = 8'h01; isr_clr = 8'h01; cyc(); clear_pulses();
        chk(0, 0, 0, "R10 set wins"); chk(1, 0, 0, "R10 set wins");

        cur_req = "R1";
        reinit = 1; cyc(); clear_pulses();
        chk(0, 0, 0, "R1 reinit"); chk(1, 0, 0, "R1 reinit");
        irq_in = 8'h00; cyc();
        irq_in = 8'h20; cyc();
        irq_in = 8'h00; cyc();
        chk(0, 0, 0, "R1 trig kept master"); chk(1, 1, 5, "R1 trig kept slave");

        cur_req = "random";
        for (int i = 0; i < 600; i++) begin
            int r = $urandom_range(0, 15);
            clear_pulses();
            irq_in = 8'($urandom);
            if (r == 0) begin trig_wr = 1; trig_data = 8'($urandom); end
            if (r == 1) begin mask_wr = 1; mask_data = 8'($urandom) & 8'h5A; end
            if (r == 2) begin rot_wr = 1; rot_data = 3'($urandom); end
            if (r == 3) isr_set = 8'(1 << $urandom_range(0, 7));
            if (r == 4) isr_clr = 8'($urandom);
            if (r == 5) irr_clr = 8'($urandom);
            if (r == 6 && $urandom_range(0, 9) == 0) reinit = 1;
            special_mask_en   = ($urandom_range(0, 3) == 0);
            special_nested_en = ($urandom_range(0, 3) == 0);
            cyc();
        end
        clear_pulses();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule